// File: doc/BRIEF.md
# Endpoint Buffer Prime and Flush Controller

This block sits between software and the endpoint engine of a USB device controller. It handles three endpoints, and each endpoint has a receive buffer and a transmit buffer. Software writes ones into a prime register to ask that buffers be prepared, and ones into a flush register to ask that prepared buffers be discarded. The block sends one single-cycle request per buffer toward the engine. It clears each request bit when the engine reports the outcome, and it keeps a read-only status word that shows which buffers are currently primed.

The engine has four inputs per buffer. It reports that priming finished, that a descriptor was retired and the endpoint needs re-priming, that a packet is in flight, and that a primed buffer has been used up. A flush on a buffer with a packet in flight is held until the packet ends. Flush always wins over priming on the same buffer.

Top module: `ep_ready_ctl`

## Requirements
- R1: After reset, the prime, flush and status registers read zero, and no prime or flush request output is asserted.
- R2: The prime register is at byte offset 0x0, the flush register at 0x4 and the status register at 0x8. In each register, bit n of bits 2:0 is the receive buffer of endpoint n and bit 16+n is the transmit buffer of endpoint n. All other bits and all other offsets read zero. Writes to those bits, and any write to the status register, change nothing.
- R3: Writing a one to a prime bit sets it. Writing a zero leaves that bit as it was.
- R4: Each newly set prime bit gives exactly one single-cycle pulse on prime_req_o, in the cycle right after the bit is set. Request vector index n is receive endpoint n, and index 3+n is transmit endpoint n.
- R5: A prime_done_i pulse on a pending buffer clears its prime bit and sets its status bit one cycle later. A prime_done_i pulse on a buffer with no pending prime is ignored.
- R6: A retire_i pulse sets the buffer's prime bit in hardware and gives a prime request pulse, just as a software prime does.
- R7: A flush bit set by software is completed in the first cycle in which the buffer has no packet in flight. That cycle carries a single flush_req_o pulse. One cycle later, the flush, prime and status bits of that buffer all read zero.
- R8: While pkt_busy_i is high for a buffer, its flush bit stays set and its status bit keeps its value.
- R9: A consume_i pulse clears the buffer's status bit.
- R10: While a flush is pending on a buffer, or is being written to it in the same cycle, prime writes and retire pulses for that buffer are dropped. A prime_done_i pulse in that period does not set the status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational by default) |
| prime_req_o | output | 6 | Per-buffer prime request pulse |
| flush_req_o | output | 6 | Per-buffer flush request pulse |
| prime_done_i | input | 6 | Engine: priming finished |
| retire_i | input | 6 | Engine: descriptor retired, re-prime needed |
| pkt_busy_i | input | 6 | Engine: packet in flight |
| consume_i | input | 6 | Engine: primed buffer used up |

## Verification
A corrupted pending or issued flag shows at the ports on the next clock. It appears either as a missing or repeated prime_req_o pulse or as a wrong prime register read. A lost flush-pending flag shows as a flush bit that clears while pkt_busy_i is still high, or as a flush_req_o pulse that never comes once busy drops. A wrong status flag shows on the very next status read after a prime_done_i, consume_i or flush completion, so every engine event in the bench is followed at once by a register read.

// File: rtl/ep_ctl_pkg.sv
`timescale 1ns/1ps
package ep_ctl_pkg;

   // Word index of each register (byte offset divided by four)
   typedef enum logic [1:0] {
      SEL_PRIME = 2'd0,
      SEL_FLUSH = 2'd1,
      SEL_STAT  = 2'd2,
      SEL_NONE  = 2'd3
   } reg_sel_e;

   // Register bit carrying buffer b: receive buffers first, then transmit
   function automatic int buf_pos(input int b, input int n_ep,
                                  input int rx_lsb, input int tx_lsb);
      return (b < n_ep) ? (rx_lsb + b) : (tx_lsb + b - n_ep);
   endfunction

endpackage

// File: rtl/ep_buf_slot.sv
`timescale 1ns/1ps
module ep_buf_slot (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_prime_i,
   input  logic wr_flush_i,
   input  logic retire_i,
   input  logic done_i,
   input  logic busy_i,
   input  logic consume_i,
   output logic pend_o,
   output logic flush_pend_o,
   output logic ready_o,
   output logic prime_req_o,
   output logic flush_req_o
);

   logic pend_q, issued_q, fpend_q, ready_q;
   logic pend_d, issued_d, fpend_d, ready_d;
   logic blocked, prime_set, flush_fire, done_hit;

   // A flush in flight, or one being written now, blocks every prime source
   assign blocked    = wr_flush_i | fpend_q;
   assign prime_set  = (wr_prime_i | retire_i) & ~blocked;
   assign flush_fire = fpend_q & ~busy_i;
   assign done_hit   = pend_q & done_i;

   always_comb begin
      pend_d   = ((pend_q & ~done_i) | prime_set) & ~flush_fire;
      // a fresh request needs a fresh pulse when the old one just completed
      issued_d = pend_d & ~done_hit & (issued_q | pend_q);
      fpend_d  = wr_flush_i | (fpend_q & busy_i);
      if (flush_fire)
         ready_d = 1'b0;
      else if (done_hit && !blocked)
         ready_d = 1'b1;
      else if (consume_i)
         ready_d = 1'b0;
      else
         ready_d = ready_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q   <= 1'b0;
         issued_q <= 1'b0;
         fpend_q  <= 1'b0;
         ready_q  <= 1'b0;
      end else begin
         pend_q   <= pend_d;
         issued_q <= issued_d;
         fpend_q  <= fpend_d;
         ready_q  <= ready_d;
      end
   end

   assign pend_o       = pend_q;
   assign flush_pend_o = fpend_q;
   assign ready_o      = ready_q;
   assign prime_req_o  = pend_q & ~issued_q;
   assign flush_req_o  = flush_fire;

   assert_req_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (prime_req_o && !done_i) |=> !prime_req_o)
      else $error("prime request longer than one cycle");

   assert_flush_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fpend_q && busy_i) |=> fpend_q)
      else $error("flush finished during a packet");

   assert_flush_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      flush_req_o |=> (!ready_q && !pend_q))
      else $error("flush left buffer primed");

   assert_flush_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_req_o && !wr_flush_i) |=> !flush_req_o)
      else $error("flush request repeated");

   assert_ready_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready_q) |-> $past(pend_q && done_i))
      else $error("status set without prime completion");

   assert_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((wr_flush_i || fpend_q) && !pend_q) |=> !pend_q)
      else $error("prime accepted during flush");

endmodule

// File: rtl/ep_reg_bank.sv
`timescale 1ns/1ps
module ep_reg_bank
   import ep_ctl_pkg::*;
#(
   parameter int NUM_EP    = 3,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 4,
   parameter int RX_LSB    = 0,
   parameter int TX_LSB    = 16,
   parameter bit RDATA_REG = 1'b0,
   localparam int NB       = 2 * NUM_EP
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [NB-1:0]     pend_i,
   input  logic [NB-1:0]     fpend_i,
   input  logic [NB-1:0]     ready_i,
   output logic [NB-1:0]     set_prime_o,
   output logic [NB-1:0]     set_flush_o,
   output logic [DATA_W-1:0] rdata_o
);

   function automatic logic [DATA_W-1:0] lane_mask();
      logic [DATA_W-1:0] m;
      m = '0;
      for (int b = 0; b < NB; b++)
         m[buf_pos(b, NUM_EP, RX_LSB, TX_LSB)] = 1'b1;
      return m;
   endfunction

   function automatic logic [DATA_W-1:0] place(input logic [NB-1:0] v);
      logic [DATA_W-1:0] w;
      w = '0;
      for (int b = 0; b < NB; b++)
         w[buf_pos(b, NUM_EP, RX_LSB, TX_LSB)] = v[b];
      return w;
   endfunction

   localparam logic [DATA_W-1:0] FIELD_MASK = lane_mask();

   reg_sel_e          sel;
   logic [DATA_W-1:0] rdata_c;
   logic              unused_wdata;

   assign unused_wdata = ^(wdata_i & ~FIELD_MASK);

   always_comb begin
      sel = SEL_NONE;
      if (addr_i[1:0] == 2'b00 && (addr_i >> 2) < 3)
         sel = reg_sel_e'(addr_i[3:2]);
   end

   for (genvar b = 0; b < NB; b++) begin : g_wr
      localparam int P = buf_pos(b, NUM_EP, RX_LSB, TX_LSB);
      assign set_prime_o[b] = wr_i && (sel == SEL_PRIME) && wdata_i[P];
      assign set_flush_o[b] = wr_i && (sel == SEL_FLUSH) && wdata_i[P];
   end

   always_comb begin
      unique case (sel)
         SEL_PRIME: rdata_c = place(pend_i);
         SEL_FLUSH: rdata_c = place(fpend_i);
         SEL_STAT:  rdata_c = place(ready_i);
         default:   rdata_c = '0;
      endcase
   end

   if (RDATA_REG) begin : g_rd_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rdata_o <= '0;
         else        rdata_o <= rdata_c;
      end
   end else begin : g_rd_comb
      assign rdata_o = rdata_c;
   end

   assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata_o & ~FIELD_MASK) == '0)
      else $error("reserved read bit nonzero");

   assert_stat_ro_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && sel == SEL_STAT) |-> (set_prime_o == '0 && set_flush_o == '0))
      else $error("status write leaked");

endmodule

// File: rtl/ep_ready_ctl.sv
`timescale 1ns/1ps
module ep_ready_ctl #(
   parameter int NUM_EP    = 3,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 4,
   parameter int RX_LSB    = 0,
   parameter int TX_LSB    = 16,
   parameter bit RDATA_REG = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr_i,
   input  logic [ADDR_W-1:0]   reg_addr_i,
   input  logic [DATA_W-1:0]   reg_wdata_i,
   output logic [DATA_W-1:0]   reg_rdata_o,
   output logic [2*NUM_EP-1:0] prime_req_o,
   output logic [2*NUM_EP-1:0] flush_req_o,
   input  logic [2*NUM_EP-1:0] prime_done_i,
   input  logic [2*NUM_EP-1:0] retire_i,
   input  logic [2*NUM_EP-1:0] pkt_busy_i,
   input  logic [2*NUM_EP-1:0] consume_i
);

   localparam int NB = 2 * NUM_EP;

   initial begin : param_chk
      assert (NUM_EP >= 1) else $error("NUM_EP must be positive");
      assert (RX_LSB + NUM_EP <= TX_LSB) else $error("receive lanes overlap transmit lanes");
      assert (TX_LSB + NUM_EP <= DATA_W) else $error("transmit lanes exceed data width");
      assert (ADDR_W >= 4) else $error("address too narrow for three registers");
   end

   logic [NB-1:0] set_prime, set_flush, pend, fpend, ready;

   ep_reg_bank #(
      .NUM_EP(NUM_EP), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
      .RX_LSB(RX_LSB), .TX_LSB(TX_LSB), .RDATA_REG(RDATA_REG)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
      .pend_i(pend), .fpend_i(fpend), .ready_i(ready),
      .set_prime_o(set_prime), .set_flush_o(set_flush),
      .rdata_o(reg_rdata_o)
   );

   for (genvar b = 0; b < NB; b++) begin : g_slot
      ep_buf_slot u_slot (
         .clk(clk), .rst_n(rst_n),
         .wr_prime_i(set_prime[b]), .wr_flush_i(set_flush[b]),
         .retire_i(retire_i[b]), .done_i(prime_done_i[b]),
         .busy_i(pkt_busy_i[b]), .consume_i(consume_i[b]),
         .pend_o(pend[b]), .flush_pend_o(fpend[b]), .ready_o(ready[b]),
         .prime_req_o(prime_req_o[b]), .flush_req_o(flush_req_o[b])
      );
   end

   assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (prime_req_o == '0 && flush_req_o == '0))
      else $error("requests active out of reset");

endmodule

// File: tb/ep_ready_ctl_tb.sv
`timescale 1ns/1ps
module ep_ready_ctl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] rdata;
   logic [5:0]  prime_req, flush_req;
   logic [5:0]  done = '0, retire = '0, busy = '0, consume = '0;
   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   ep_ready_ctl u_dut (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
      .reg_rdata_o(rdata),
      .prime_req_o(prime_req), .flush_req_o(flush_req),
      .prime_done_i(done), .retire_i(retire),
      .pkt_busy_i(busy), .consume_i(consume)
   );

   // {write, address, data-or-expected}
   localparam int NV = 13;
   localparam logic [36:0] VEC [NV] = '{
      {1'b0, 4'h0, 32'h0000_0000},
      {1'b0, 4'h4, 32'h0000_0000},
      {1'b0, 4'h8, 32'h0000_0000},
      {1'b0, 4'hC, 32'h0000_0000},
      {1'b1, 4'h0, 32'hFFFF_FFFF},
      {1'b0, 4'h0, 32'h0007_0007},
      {1'b1, 4'h8, 32'hFFFF_FFFF},
      {1'b0, 4'h8, 32'h0000_0000},
      {1'b1, 4'h0, 32'h0000_0000},
      {1'b0, 4'h0, 32'h0007_0007},
      {1'b1, 4'h0, 32'h0000_FFF8},
      {1'b0, 4'h0, 32'h0007_0007},
      {1'b0, 4'h4, 32'h0000_0000}
   };

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      tick();
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
      reg_addr = a;
      #1;
      chk(rdata, exp, tag);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual hung expected done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      chk({26'b0, prime_req}, 32'h0, "R1 prime_req in reset");
      rst_n = 1'b1;
      tick();
      chk({26'b0, prime_req}, 32'h0, "R1 prime_req idle");
      chk({26'b0, flush_req}, 32'h0, "R1 flush_req idle");

      // register map, write-one and reserved-bit vectors (R1 R2 R3)
      for (int i = 0; i < NV; i++) begin
         if (VEC[i][36]) wr(VEC[i][35:32], VEC[i][31:0]);
         else rd(VEC[i][35:32], VEC[i][31:0], $sformatf("R2/R3 vector %0d", i));
      end

      // R5: completion of all six primes
      done = 6'h3F; tick(); done = '0;
      rd(4'h0, 32'h0, "R5 prime bits cleared");
      rd(4'h8, 32'h0007_0007, "R5 status set");

      // R9: consume transmit endpoint 1 (index 4, bit 17)
      consume = 6'b010000; tick(); consume = '0;
      rd(4'h8, 32'h0005_0007, "R9 consume clears status");

      // R8 / R7: flush receive endpoint 0 with a packet in flight
      busy = 6'b000001;
      wr(4'h4, 32'h1);
      rd(4'h4, 32'h1, "R7 flush bit set");
      chk({26'b0, flush_req}, 32'h0, "R8 flush waits for packet");
      tick(); tick();
      rd(4'h4, 32'h1, "R8 flush still pending");
      rd(4'h8, 32'h0005_0007, "R8 status held while busy");
      busy = '0;
      #1;
      chk({26'b0, flush_req}, 32'h1, "R7 flush pulse");
      tick();
      chk({26'b0, flush_req}, 32'h0, "R7 flush pulse single");
      rd(4'h4, 32'h0, "R7 flush bit cleared");
      rd(4'h8, 32'h0005_0006, "R7 status cleared");

      // R4: prime transmit endpoint 1
      wr(4'h0, 32'h0002_0000);
      chk({26'b0, prime_req}, 32'h10, "R4 request pulse");
      tick();
      chk({26'b0, prime_req}, 32'h0, "R4 request single");
      done = 6'b010000; tick(); done = '0;
      rd(4'h8, 32'h0007_0006, "R5 transmit status set");
      rd(4'h0, 32'h0, "R5 transmit prime cleared");
      done = 6'b000001; tick(); done = '0;
      rd(4'h8, 32'h0007_0006, "R5 stray done ignored");
      chk({26'b0, prime_req}, 32'h0, "R5 stray done no request");

      // R6: hardware re-prime on retire of receive endpoint 1
      retire = 6'b000010; tick(); retire = '0;
      chk({26'b0, prime_req}, 32'h2, "R6 retire request");
      rd(4'h0, 32'h2, "R6 prime bit set by hardware");
      tick();

      // R10: flush has priority over priming
      consume = 6'b000010; tick(); consume = '0;
      rd(4'h8, 32'h0007_0004, "R9 consume receive 1");
      busy = 6'b000010;
      wr(4'h4, 32'h2);
      rd(4'h4, 32'h2, "R8 flush pending receive 1");
      done = 6'b000010; tick(); done = '0;
      rd(4'h8, 32'h0007_0004, "R10 done during flush not primed");
      retire = 6'b000010; tick(); retire = '0;
      rd(4'h0, 32'h0, "R10 retire dropped");
      chk({26'b0, prime_req}, 32'h0, "R10 no request");
      wr(4'h0, 32'h2);
      rd(4'h0, 32'h0, "R10 prime write dropped");
      busy = '0;
      #1;
      chk({26'b0, flush_req}, 32'h2, "R7 flush pulse receive 1");
      tick();
      rd(4'h4, 32'h0, "R7 flush receive 1 cleared");
      rd(4'h8, 32'h0007_0004, "R7 other status kept");

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule